// File: doc/BRIEF.md
# Packet Formatter Output Sequencer

This block sits between the channel buffers of a multi-channel data merger and a downstream packet sink. An arbiter in front of it names one channel, gives that channel's 3-bit length code and tells how many 32-bit words the channel currently holds. Once that channel holds at least one whole packet, the sequencer latches the channel number and the packet length and raises a request toward the sink. It then waits for the grant, and after that streams the packet out one word per clock, popping the channel buffer as it goes.

Packet length is derived from the low two bits of the length code only: 4 shifted left by that two-bit value, so a packet is 4, 8, 16 or 32 words long. The first word carries a start-of-packet flag and the last word carries an end-of-packet flag. The only back-pressure is a grant that the sink withholds. Once granted, a burst never stalls, so the channel named on the output must deliver a fresh head word on `src_word` in every cycle in which `src_pop` is high. The word it presents is the one that the pop in that cycle removes.

Top module: `pkt_fmt_seq`

## Requirements
- R1: The packet length is 4 << (sel_code & 3), giving 4, 8, 16 or 32; bit 2 of the code has no effect. While `fmt_req` is high, `fmt_len` shows that length.
- R2: A request is raised only after a clock edge at which `sel_valid` was high and `sel_count` was at least the packet length of the selected channel. With `sel_valid` low, or with too few words held, `fmt_req` stays low.
- R3: A selection naming channel 3 is ignored and raises no request. `fmt_chid` is 0, 1 or 2 whenever `fmt_req` or `fmt_valid` is high.
- R4: From the cycle `fmt_req` rises until the grant is sampled, `fmt_req`, `fmt_chid` and `fmt_len` hold steady, even if the selection inputs change.
- R5: In the cycle after `fmt_grant` is sampled high with `fmt_req`, the request is low and `fmt_valid` with `src_pop` is high. They stay high for exactly `fmt_len` consecutive cycles.
- R6: `fmt_sop` is high only on the first word of a packet and `fmt_eop` only on the last. Both are high only together with `fmt_valid`.
- R7: `fmt_data` carries the words of the latched channel, in the order they were pushed into it, with no word skipped or repeated.
- R8: During and after reset, `fmt_req`, `fmt_valid`, `fmt_sop`, `fmt_eop` and `src_pop` are low, and `fmt_chid` and `fmt_len` are 0.
- R9: After the last word the block is idle for one cycle. If the selection is still satisfied, the next request rises on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Arbiter has a channel selected |
| sel_id | input | 2 | Selected channel number |
| sel_code | input | 3 | Length code of the selected channel |
| sel_count | input | 6 | Words currently held by the selected channel |
| src_word | input | 32 | Head word of the channel on `fmt_chid` |
| src_pop | output | 1 | Removes the head word of that channel |
| fmt_req | output | 1 | Packet ready, asking the sink for a grant |
| fmt_grant | input | 1 | Sink accepts the pending packet |
| fmt_chid | output | 2 | Source channel of the packet |
| fmt_len | output | 6 | Packet length in words |
| fmt_valid | output | 1 | `fmt_data` carries a packet word |
| fmt_data | output | 32 | Packet word |
| fmt_sop | output | 1 | First word of the packet |
| fmt_eop | output | 1 | Last word of the packet |

## Verification
The bench drives a channel one word short of a packet. A sequencer that compares against the wrong length, or decodes the full 3-bit code, would request early, or wait for 32 words when code 5 asks for 8. It changes the selection while a request waits for a delayed grant, which catches a design that re-latches the channel or length, and it points the selector at channel 3, which a design lacking the range check would serve. Back-to-back packets from one channel check that the word counter restarts, so that a stale counter does not shorten the second packet or mark its start wrongly.

// File: rtl/pkt_fmt_pkg.sv
package pkt_fmt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } fmt_state_e;
endpackage

// File: rtl/pkt_fmt_len.sv
module pkt_fmt_len #(
  parameter int CODE_W   = 3,
  parameter int SEL_W    = 2,
  parameter int BASE_LEN = 4,
  parameter int CNT_W    = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  len
);
  localparam int NLEN = 1 << SEL_W;

  logic [CNT_W-1:0] len_tbl [NLEN];

  for (genvar g = 0; g < NLEN; g++) begin : g_tbl
    assign len_tbl[g] = CNT_W'(BASE_LEN << g);
  end

  assign len = len_tbl[code[SEL_W-1:0]];

  if (CODE_W > SEL_W) begin : g_hi
    logic unused_code_hi;
    assign unused_code_hi = ^code[CODE_W-1:SEL_W];
  end
endmodule

// File: rtl/pkt_fmt_beat.sv
module pkt_fmt_beat #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] len,
  output logic             first,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign first = (cnt == '0);
  assign last  = (cnt == len - 1'b1);
endmodule

// File: rtl/pkt_fmt_ctl.sv
module pkt_fmt_ctl import pkt_fmt_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_ok,
  input  logic       grant,
  input  logic       last,
  output fmt_state_e state,
  output logic       load,
  output logic       burst
);
  fmt_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (sel_ok) nxt = ST_WAIT;
      ST_WAIT:  if (grant)  nxt = ST_BURST;
      ST_BURST: if (last)   nxt = ST_IDLE;
      default:              nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign load  = (state == ST_IDLE) && sel_ok;
  assign burst = (state == ST_BURST);
endmodule

// File: rtl/pkt_fmt_seq.sv
module pkt_fmt_seq import pkt_fmt_pkg::*; #(
  parameter int DW       = 32,
  parameter int NCH      = 3,
  parameter int IDW      = 2,
  parameter int CODE_W   = 3,
  parameter int SEL_W    = 2,
  parameter int BASE_LEN = 4,
  localparam int MAX_LEN = BASE_LEN << ((1 << SEL_W) - 1),
  localparam int CNT_W   = $clog2(MAX_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [IDW-1:0]    sel_id,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [CNT_W-1:0]  sel_count,
  input  logic [DW-1:0]     src_word,
  output logic              src_pop,
  output logic              fmt_req,
  input  logic              fmt_grant,
  output logic [IDW-1:0]    fmt_chid,
  output logic [CNT_W-1:0]  fmt_len,
  output logic              fmt_valid,
  output logic [DW-1:0]     fmt_data,
  output logic              fmt_sop,
  output logic              fmt_eop
);
  logic [CNT_W-1:0] dec_len;
  logic [CNT_W-1:0] len_q;
  logic [IDW-1:0]   id_q;
  logic             sel_ok, load, burst, first, last;
  fmt_state_e       st;

  pkt_fmt_len #(
    .CODE_W(CODE_W), .SEL_W(SEL_W), .BASE_LEN(BASE_LEN), .CNT_W(CNT_W)
  ) u_len (
    .code(sel_code),
    .len (dec_len)
  );

  assign sel_ok = sel_valid
                && ({1'b0, sel_id} < (IDW+1)'(NCH))
                && (sel_count >= dec_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      len_q <= '0;
    end else if (load) begin
      id_q  <= sel_id;
      len_q <= dec_len;
    end
  end

  pkt_fmt_ctl u_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .sel_ok(sel_ok),
    .grant(fmt_grant),
    .last (last),
    .state(st),
    .load (load),
    .burst(burst)
  );

  pkt_fmt_beat #(.CNT_W(CNT_W)) u_beat (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(load),
    .step (burst),
    .len  (len_q),
    .first(first),
    .last (last)
  );

  assign fmt_req   = (st == ST_WAIT);
  assign fmt_valid = burst;
  assign src_pop   = burst;
  assign fmt_chid  = id_q;
  assign fmt_len   = len_q;
  assign fmt_data  = burst ? src_word : '0;
  assign fmt_sop   = burst && first;
  assign fmt_eop   = burst && last;
endmodule

// File: rtl/pkt_fmt_seq_chk.sv
module pkt_fmt_seq_chk #(
  parameter int NCH     = 3,
  parameter int IDW     = 2,
  parameter int CNT_W   = 6,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] sel_count,
  input logic             fmt_req,
  input logic             fmt_grant,
  input logic [IDW-1:0]   fmt_chid,
  input logic [CNT_W-1:0] fmt_len,
  input logic             fmt_valid,
  input logic             fmt_sop,
  input logic             fmt_eop
);
  logic [CNT_W-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     beats <= '0;
    else if (fmt_valid && !fmt_eop) beats <= beats + 1'b1;
    else                            beats <= '0;
  end

  a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_req |-> ($countones(fmt_len) == 1 && fmt_len >= CNT_W'(MIN_LEN)
                 && fmt_len <= CNT_W'(MAX_LEN)));

  a_r2_enough_words: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_req) |-> ($past(sel_count) >= fmt_len));

  a_r3_chid_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_req || fmt_valid) |-> ({1'b0, fmt_chid} < (IDW+1)'(NCH)));

  a_r4_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_req && !fmt_grant) |=> (fmt_req && $stable(fmt_chid) && $stable(fmt_len)));

  a_r5_burst_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_req && fmt_grant) |=> (!fmt_req && fmt_valid && fmt_sop));

  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid && !fmt_eop) |=> fmt_valid);

  a_r6_marks_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sop || fmt_eop) |-> fmt_valid);

  a_r6_eop_count: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_eop |-> (beats == fmt_len - 1'b1));

  a_r9_idle_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_eop |=> (!fmt_valid && !fmt_req));
endmodule

bind pkt_fmt_seq pkt_fmt_seq_chk #(
  .NCH(NCH), .IDW(IDW), .CNT_W(CNT_W), .MIN_LEN(BASE_LEN), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_count(sel_count),
  .fmt_req  (fmt_req),
  .fmt_grant(fmt_grant),
  .fmt_chid (fmt_chid),
  .fmt_len  (fmt_len),
  .fmt_valid(fmt_valid),
  .fmt_sop  (fmt_sop),
  .fmt_eop  (fmt_eop)
);

// File: tb/pkt_fmt_seq_bench.sv
`timescale 1ns/1ps
module pkt_fmt_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_valid = 1'b0;
  logic [1:0]  sel_id = '0;
  logic [2:0]  sel_code = '0;
  logic [5:0]  sel_count = '0;
  logic [31:0] src_word = '0;
  logic        fmt_grant = 1'b0;
  logic        src_pop, fmt_req, fmt_valid, fmt_sop, fmt_eop;
  logic [1:0]  fmt_chid;
  logic [5:0]  fmt_len;
  logic [31:0] fmt_data;

  always #10 clk = ~clk;

  pkt_fmt_seq u_pkt_fmt_seq (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_id(sel_id),
    .sel_code(sel_code), .sel_count(sel_count), .src_word(src_word),
    .src_pop(src_pop), .fmt_req(fmt_req), .fmt_grant(fmt_grant),
    .fmt_chid(fmt_chid), .fmt_len(fmt_len), .fmt_valid(fmt_valid),
    .fmt_data(fmt_data), .fmt_sop(fmt_sop), .fmt_eop(fmt_eop)
  );

  logic [31:0] chq [4][$];
  int push_seq [4];
  int exp_seq  [4];
  int m_st, m_chid, m_len, m_beat, pkts;
  int gdelay, req_wait;
  bit pop_seen;
  int pop_ch_seen;
  int total, bad;
  bit done;

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic refresh();
    int n;
    n = chq[sel_id].size();
    sel_count = 6'((n > 63) ? 63 : n);
    src_word  = (chq[fmt_chid].size() > 0) ? chq[fmt_chid][0] : 32'h0;
  endtask

  task automatic push(int ch, int n);
    for (int i = 0; i < n; i++) begin
      chq[ch].push_back(32'((ch << 24) | push_seq[ch]));
      push_seq[ch]++;
    end
    refresh();
  endtask

  task automatic set_sel(bit v, int id, int code);
    sel_valid = v;
    sel_id    = 2'(id);
    sel_code  = 3'(code);
    refresh();
  endtask

  task automatic compare();
    bit er, ev;
    er = (m_st == 1);
    ev = (m_st == 2);
    chk("R2", "fmt_req", fmt_req, er);
    chk("R5", "fmt_valid", fmt_valid, ev);
    chk("R5", "src_pop", src_pop, ev);
    chk("R6", "fmt_sop", fmt_sop, ev && m_beat == 0);
    chk("R6", "fmt_eop", fmt_eop, ev && m_beat == m_len - 1);
    if (er || ev) begin
      chk("R3", "fmt_chid", fmt_chid, m_chid);
      chk("R1", "fmt_len", fmt_len, m_len);
    end
    if (ev) chk("R7", "fmt_data", fmt_data, (m_chid << 24) | exp_seq[m_chid]);
  endtask

  task automatic tick();
    @(negedge clk);
    if (fmt_req) begin
      req_wait++;
      fmt_grant = (req_wait > gdelay);
    end else begin
      req_wait  = 0;
      fmt_grant = 1'b0;
    end
    refresh();
    #2;
    compare();
    pop_seen    = src_pop;
    pop_ch_seen = int'(fmt_chid);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_beat = 0; m_chid = 0; m_len = 0;
    end else begin
      case (m_st)
        0: if (sel_valid && sel_id < 3 &&
               chq[sel_id].size() >= (4 << (sel_code & 3))) begin
             m_st = 1; m_chid = int'(sel_id); m_len = 4 << (sel_code & 3);
           end
        1: if (fmt_grant) begin m_st = 2; m_beat = 0; end
        2: begin
             exp_seq[m_chid]++;
             if (m_beat == m_len - 1) begin m_st = 0; pkts++; end
             else m_beat++;
           end
        default: m_st = 0;
      endcase
      if (pop_seen && chq[pop_ch_seen].size() > 0) void'(chq[pop_ch_seen].pop_front());
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin push_seq[c] = 0; exp_seq[c] = 0; end
    pkts = 0; total = 0; bad = 0; gdelay = 1; req_wait = 0; pop_seen = 0; done = 0;
    run(3);
    // R8: reset state
    chk("R8", "reset fmt_req", fmt_req, 0);
    chk("R8", "reset fmt_valid", fmt_valid, 0);
    chk("R8", "reset src_pop", src_pop, 0);
    chk("R8", "reset fmt_sop|eop", fmt_sop | fmt_eop, 0);
    chk("R8", "reset fmt_len", fmt_len, 0);
    chk("R8", "reset fmt_chid", fmt_chid, 0);
    rst_n = 1'b1;
    run(2);

    // R1: shortest packet, channel 0, grant after one extra cycle
    gdelay = 1; set_sel(1, 0, 0); push(0, 4);
    run(12);
    chk("R1", "packets after len4", pkts, 1);
    set_sel(0, 0, 0);

    // R1 code 5 -> 8 words; R4 selection changes while waiting
    gdelay = 3; set_sel(1, 1, 5); push(1, 8);
    run(2);
    chk("R4", "req raised before sel change", fmt_req, 1);
    set_sel(1, 2, 3);
    run(20);
    chk("R1", "packets after code5", pkts, 2);

    // R2: one word short, no request
    set_sel(1, 2, 2); gdelay = 2; push(2, 15);
    run(10);
    chk("R2", "no req with 15 of 16", fmt_req, 0);
    push(2, 1);
    run(30);
    chk("R2", "packets after 16 words", pkts, 3);

    // R3: channel 3 ignored
    set_sel(1, 3, 0); push(3, 8);
    run(8);
    chk("R3", "no req for channel 3", fmt_req, 0);
    chk("R3", "packets unchanged", pkts, 3);

    // R2: sel_valid low blocks; then 32-word packet
    set_sel(0, 0, 3); push(0, 32);
    run(6);
    chk("R2", "no req with sel_valid low", fmt_req, 0);
    set_sel(1, 0, 3);
    run(45);
    chk("R1", "packets after len32", pkts, 4);
    set_sel(0, 0, 0);
    run(2);

    // R9: back-to-back packets from channel 2
    gdelay = 1; push(2, 8); set_sel(1, 2, 0);
    run(25);
    chk("R9", "back-to-back packets", pkts, 6);
    set_sel(0, 0, 0);
    run(2);

    // R7: every pushed word left through the port
    for (int c = 0; c < 3; c++) chk("R7", "channel drained", chq[c].size(), 0);
    chk("R3", "channel 3 untouched", chq[3].size(), 8);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule